// File: doc/BRIEF.md
# Hold-Acknowledge DMA Bus Sequencer

This block is the bus-side engine of a DMA controller. It takes single transfer requests (address, direction, size and write data) over a valid/ready handshake. For each one it wins the system bus by raising a hold request and waiting for the hold acknowledge. It then runs one memory read or write cycle. When no further request is waiting, it hands the bus back. Read data comes back with a one-cycle done pulse.

The external bus has a 24-bit address. The upper eight address bits share pins with the upper data byte. For one cycle an address strobe lets outside logic latch those bits, and after that the same pins carry data. While the block owns the bus it raises an address-enable output, which gates the external latch onto the system bus and holds other drivers off. A ready input adds wait states to the memory strobes.

A static strap selects byte or word bus width. In word mode an active-low upper-byte-enable output, together with address bit 0, tells memory which data lanes are valid. Every bus pin has its own output-enable signal, so the pad ring can build the three-state drivers.

Top module: `hold_dma_seq`

## Requirements
- R1: After a request is accepted, `hold_req` rises in the next cycle. `aen` and every bus output enable stay low until `hold_ack` has been sampled high. The address phase starts in the cycle after that sample.
- R2: The address phase lasts exactly one cycle. In it `astb`=1, `addr_lo` equals address bits 15..0, `mux_out` equals address bits 23..16 with `mux_oe`=1, and `rd_n`=`wr_n`=1.
- R3: `aen` is 1 in every cycle from the address phase up to and including the release cycle.
- R4: While `ready` is sampled 0, the active strobe (`rd_n` for reads, `wr_n` for writes) stays low. It goes high in the cycle after `ready` is sampled 1, provided the minimum strobe time has been served.
- R5: With `ready` held at 1, the strobe is low for exactly `STRB_CYC` (2) cycles.
- R6: In byte mode (`width_strap`=0), `ube_oe` stays 0. Data uses only the low lane `dlo_*`, with write data taken from `req_wdata[7:0]`. Reads return `{8'h00, low lane}` on `rdata`.
- R7: In word mode (`width_strap`=1), the lanes are encoded as follows, with write data driven only on the lanes in use:
  - `ube_n`=0 with A0=0 (a word access at an even address) uses both lanes, the even byte on the low lane; a write drives `req_wdata`, a read returns `{upper, low}`.
  - `ube_n`=1 with A0=0 uses the low lane only; a write drives `req_wdata[7:0]` there.
  - `ube_n`=0 with A0=1 uses the upper lane only; a write drives `req_wdata[7:0]` there.
  - A read of a single lane returns that lane's byte in `rdata[7:0]` with zero above it.
- R8: When the block is not bus master, all of these are 0: `addr_oe`, `mux_oe`, `dlo_oe`, `strobe_oe`, `ube_oe`, `astb` and `aen`. `hold_req` is also 0 whenever the block is idle.
- R9: After the last cycle the release takes two cycles:
  - first, a done cycle with the strobes high and the address still driven;
  - then a cycle with the address, strobe, data and upper-byte-enable outputs floated while `aen` and `hold_req` stay 1;
  - after that, `aen` and `hold_req` are both 0.
- R10: In idle, `req_ready` is 0 while `hold_ack` is still 1, so a request offered then is not taken. It becomes 1 once `hold_ack` is 0.
- R11: `done` is a pulse of exactly one cycle. For a read, `rdata` holds the read value in that cycle.
- R12: A request offered during the done cycle is accepted (`req_ready`=1). Its address phase follows in the next cycle, with `hold_req` never dropping between the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| width_strap | input | 1 | Static width strap: 0 byte bus, 1 word bus |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Transfer request accepted this cycle when valid |
| req_addr | input | 24 | Transfer byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 requests a 16-bit access (word mode, even address) |
| req_wdata | input | 16 | Write data; single bytes in bits 7..0 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, right-aligned |
| hold_req | output | 1 | Bus hold request |
| hold_ack | input | 1 | Bus hold acknowledge |
| aen | output | 1 | Address enable while bus master |
| astb | output | 1 | Upper-address latch strobe |
| ready | input | 1 | Memory ready; 0 inserts wait states |
| addr_lo | output | 16 | Address bits 15..0 |
| addr_oe | output | 1 | Output enable for addr_lo |
| mux_out | output | 8 | Shared upper address / upper data lane, driven value |
| mux_in | input | 8 | Shared upper lane, sampled value |
| mux_oe | output | 1 | Output enable for the shared lane |
| dlo_out | output | 8 | Low data lane, driven value |
| dlo_in | input | 8 | Low data lane, sampled value |
| dlo_oe | output | 1 | Output enable for the low lane |
| rd_n | output | 1 | Memory read strobe, active low |
| wr_n | output | 1 | Memory write strobe, active low |
| strobe_oe | output | 1 | Output enable for rd_n and wr_n |
| ube_n | output | 1 | Upper byte enable, active low |
| ube_oe | output | 1 | Output enable for ube_n |

## Verification
The bench sweeps every combination of the width strap, address bit 0, the size flag, the direction, and zero to three wait states, with a varying hold-acknowledge delay. Comparing the three lane encodings against byte mode separates each lane-steering and upper-byte-enable case. The stretched strobes and the acknowledge delay each show whether a counter or an input sample controls each phase edge. A chained pair of accesses is run to show that the bus is kept between them. A request offered while acknowledge is still high after a release must be refused.

// File: rtl/hold_dma_pkg.sv
// Shared types of the hold-acknowledge DMA bus sequencer.
package hold_dma_pkg;
    // Sequencer phases, in the order a single access walks through them.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // bus slave, waiting for a request
        ST_REQ  = 3'd1,  // hold requested, waiting for acknowledge
        ST_ADDR = 3'd2,  // address phase with latch strobe
        ST_STRB = 3'd3,  // memory strobe low, waits on ready
        ST_DONE = 3'd4,  // strobe high, result presented
        ST_REL  = 3'd5   // lines floated, enable and request held
    } seq_st_t;
endpackage

// File: rtl/hds_seq_fsm.sv
// Phase sequencer: owns the state and the minimum-strobe counter.
// Assumes hold_ack stays high for as long as hold_req is high once granted.
module hds_seq_fsm
    import hold_dma_pkg::*;
#(
    parameter int STRB_CYC = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    hold_ack,
    input  logic    ready,
    output seq_st_t state,
    output logic    req_ready,
    output logic    strb_end
);
    localparam int CNT_W = (STRB_CYC > 1) ? $clog2(STRB_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRB_CYC - 1);

    seq_st_t          st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             fire;

    // Acceptance: idle with acknowledge gone, or the done cycle (chaining).
    always_comb begin
        req_ready = ((st_q == ST_IDLE) && !hold_ack) || (st_q == ST_DONE);
        fire      = req_valid && req_ready;
        strb_end  = (st_q == ST_STRB) && (cnt_q == CNT_LAST) && ready;
    end

    // Next-phase selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (fire) st_d = ST_REQ;
            ST_REQ:  if (hold_ack) st_d = ST_ADDR;
            ST_ADDR: st_d = ST_STRB;
            ST_STRB: if (strb_end) st_d = ST_DONE;
            ST_DONE: st_d = fire ? ST_ADDR : ST_REL;
            ST_REL:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Phase register and saturating strobe-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != ST_STRB)
                cnt_q <= '0;
            else if (cnt_q != CNT_LAST)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign state = st_q;
endmodule

// File: rtl/hds_lane_map.sv
// Data-lane steering: picks the lanes in use from the width strap, address
// bit 0 and the size flag, places write bytes and right-aligns read data.
// Assumes a word access is only meaningful at an even address; at an odd
// address it is served as the single upper-lane byte.
module hds_lane_map #(
    parameter int LANE_W = 8
) (
    input  logic                word_mode,
    input  logic                addr0,
    input  logic                size_word,
    input  logic [2*LANE_W-1:0] wdata,
    input  logic [LANE_W-1:0]   lo_in,
    input  logic [LANE_W-1:0]   hi_in,
    output logic                use_lo,
    output logic                use_hi,
    output logic                ube_n,
    output logic [LANE_W-1:0]   wr_lo,
    output logic [LANE_W-1:0]   wr_hi,
    output logic [2*LANE_W-1:0] rd_val
);
    // Lane selection and byte placement.
    always_comb begin
        use_hi = word_mode && (addr0 || size_word);
        use_lo = !word_mode || !addr0;
        ube_n  = !use_hi;
        wr_lo  = wdata[LANE_W-1:0];
        wr_hi  = addr0 ? wdata[LANE_W-1:0] : wdata[2*LANE_W-1:LANE_W];
        if (use_lo && use_hi)
            rd_val = {hi_in, lo_in};
        else if (use_hi)
            rd_val = {{LANE_W{1'b0}}, hi_in};
        else
            rd_val = {{LANE_W{1'b0}}, lo_in};
    end
endmodule

// File: rtl/hold_dma_seq.sv
// Hold-acknowledge DMA bus master sequencer (top).
// Accepts single transfers, wins the bus by hold request/acknowledge, runs
// one strobed memory cycle per transfer on a bus whose upper address byte is
// multiplexed with the upper data byte, and hands the bus back in two steps.
// Assumes width_strap is static and hold_ack stays high while granted.
module hold_dma_seq
    import hold_dma_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LANE_W   = 8,
    parameter int STRB_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                width_strap,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic                req_word,
    input  logic [2*LANE_W-1:0] req_wdata,
    output logic                done,
    output logic [2*LANE_W-1:0] rdata,
    output logic                hold_req,
    input  logic                hold_ack,
    output logic                aen,
    output logic                astb,
    input  logic                ready,
    output logic [ADDR_W-LANE_W-1:0] addr_lo,
    output logic                addr_oe,
    output logic [LANE_W-1:0]   mux_out,
    input  logic [LANE_W-1:0]   mux_in,
    output logic                mux_oe,
    output logic [LANE_W-1:0]   dlo_out,
    input  logic [LANE_W-1:0]   dlo_in,
    output logic                dlo_oe,
    output logic                rd_n,
    output logic                wr_n,
    output logic                strobe_oe,
    output logic                ube_n,
    output logic                ube_oe
);
    localparam int DATA_W = 2 * LANE_W;
    localparam int LO_W   = ADDR_W - LANE_W;

    seq_st_t           st;
    logic              strb_end;
    logic              fire;
    logic [ADDR_W-1:0] q_addr;
    logic              q_write;
    logic              q_word;
    logic [DATA_W-1:0] q_wdata;
    logic [DATA_W-1:0] rdata_q;
    logic              use_lo, use_hi, lane_ube_n;
    logic [LANE_W-1:0] wr_lo, wr_hi;
    logic [DATA_W-1:0] rd_val;
    logic              on_bus, in_strb;

    hds_seq_fsm #(.STRB_CYC(STRB_CYC)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hold_ack  (hold_ack),
        .ready     (ready),
        .state     (st),
        .req_ready (req_ready),
        .strb_end  (strb_end)
    );

    hds_lane_map #(.LANE_W(LANE_W)) lane_i (
        .word_mode (width_strap),
        .addr0     (q_addr[0]),
        .size_word (q_word),
        .wdata     (q_wdata),
        .lo_in     (dlo_in),
        .hi_in     (mux_in),
        .use_lo    (use_lo),
        .use_hi    (use_hi),
        .ube_n     (lane_ube_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .rd_val    (rd_val)
    );

    assign fire = req_valid && req_ready;

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_write <= 1'b0;
            q_word  <= 1'b0;
            q_wdata <= '0;
        end else if (fire) begin
            q_addr  <= req_addr;
            q_write <= req_write;
            q_word  <= req_word;
            q_wdata <= req_wdata;
        end
    end

    // Read data capture on the edge that ends the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (strb_end && !q_write)
            rdata_q <= rd_val;
    end

    // Phase decode into bus controls and enables.
    always_comb begin
        on_bus    = (st == ST_ADDR) || (st == ST_STRB) || (st == ST_DONE);
        in_strb   = (st == ST_STRB);
        hold_req  = (st != ST_IDLE);
        aen       = on_bus || (st == ST_REL);
        astb      = (st == ST_ADDR);
        addr_lo   = q_addr[LO_W-1:0];
        addr_oe   = on_bus;
        strobe_oe = on_bus;
        rd_n      = !(in_strb && !q_write);
        wr_n      = !(in_strb && q_write);
        mux_out   = (st == ST_ADDR) ? q_addr[ADDR_W-1:LO_W] : wr_hi;
        mux_oe    = (st == ST_ADDR) || (in_strb && q_write && use_hi);
        dlo_out   = wr_lo;
        dlo_oe    = in_strb && q_write && use_lo;
        ube_n     = lane_ube_n;
        ube_oe    = width_strap && on_bus;
        done      = (st == ST_DONE);
        rdata     = rdata_q;
    end
endmodule

// File: rtl/hold_dma_seq_chk.sv
// Protocol checker for hold_dma_seq, attached by bind. Observes ports only.
module hold_dma_seq_chk #(
    parameter int ADDR_W = 24,
    parameter int LANE_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic width_strap,
    input logic req_valid,
    input logic hold_req,
    input logic hold_ack,
    input logic aen,
    input logic astb,
    input logic ready,
    input logic addr_oe,
    input logic mux_oe,
    input logic dlo_oe,
    input logic rd_n,
    input logic wr_n,
    input logic strobe_oe,
    input logic ube_oe,
    input logic done
);
    logic strobe_act;
    assign strobe_act = !rd_n || !wr_n;

    p_aen_after_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aen) |-> $past(hold_ack));
    p_astb_addr_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        astb |-> (mux_oe && addr_oe && aen && rd_n && wr_n));
    p_wait_holds_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_act && !ready) |=> strobe_act);
    p_strobe_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_act) |=> strobe_act);
    p_byte_ube_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !width_strap |-> !ube_oe);
    p_slave_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !aen |-> (!addr_oe && !mux_oe && !dlo_oe && !strobe_oe && !ube_oe && !astb));
    p_release_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aen) |-> ($fell(hold_req) && $past(!addr_oe && !strobe_oe && !mux_oe)));
    p_no_rerequest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> !$past(hold_ack));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_chain_keeps_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid) |=> (astb && hold_req));
endmodule

bind hold_dma_seq hold_dma_seq_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .width_strap (width_strap),
    .req_valid   (req_valid),
    .hold_req    (hold_req),
    .hold_ack    (hold_ack),
    .aen         (aen),
    .astb        (astb),
    .ready       (ready),
    .addr_oe     (addr_oe),
    .mux_oe      (mux_oe),
    .dlo_oe      (dlo_oe),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .strobe_oe   (strobe_oe),
    .ube_oe      (ube_oe),
    .done        (done)
);

// File: tb/hold_dma_seq_tb.sv
// Sweep bench for hold_dma_seq: every strap/A0/size/direction combination
// with 0..3 wait states and varying acknowledge delay, plus chaining.
module hold_dma_seq_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        width_strap = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic        hold_req;
    logic        hold_ack = 1'b0;
    logic        aen, astb;
    logic        ready = 1'b1;
    logic [15:0] addr_lo;
    logic        addr_oe;
    logic [7:0]  mux_out;
    logic [7:0]  mux_in = '0;
    logic        mux_oe;
    logic [7:0]  dlo_out;
    logic [7:0]  dlo_in = '0;
    logic        dlo_oe;
    logic        rd_n, wr_n, strobe_oe, ube_n, ube_oe;

    int n_vec = 0;
    int n_bad = 0;

    hold_dma_seq dut_i (
        .clk(clk), .rst_n(rst_n), .width_strap(width_strap),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .hold_req(hold_req), .hold_ack(hold_ack),
        .aen(aen), .astb(astb), .ready(ready), .addr_lo(addr_lo),
        .addr_oe(addr_oe), .mux_out(mux_out), .mux_in(mux_in), .mux_oe(mux_oe),
        .dlo_out(dlo_out), .dlo_in(dlo_in), .dlo_oe(dlo_oe), .rd_n(rd_n),
        .wr_n(wr_n), .strobe_oe(strobe_oe), .ube_n(ube_n), .ube_oe(ube_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Floated-bus check for the slave phases.
    task automatic chk_slave(input string tag);
        chk(!aen && !astb && !addr_oe && !mux_oe && !dlo_oe && !strobe_oe && !ube_oe,
            tag, {aen, astb, addr_oe, mux_oe, dlo_oe, strobe_oe, ube_oe}, 0);
    endtask

    task automatic set_req(input logic [23:0] a, input bit wd, input bit wr,
                           input logic [15:0] d);
        req_valid = 1'b1; req_addr = a; req_word = wd; req_write = wr; req_wdata = d;
    endtask

    // From acceptance through the acknowledge; ends just before the address phase edge.
    task automatic grant(input int ack_delay);
        @(negedge clk); req_valid = 1'b0; #1;
        chk(hold_req == 1'b1, "R1 hold_req after accept", hold_req, 1);
        chk_slave("R1 no drive before ack");
        for (int i = 0; i < ack_delay; i++) begin
            @(negedge clk); #1;
            chk(hold_req && !aen && !addr_oe, "R1 waiting for ack", {hold_req, aen, addr_oe}, 3'b100);
        end
        hold_ack = 1'b1;
    endtask

    // Address phase, strobe phase and done cycle of one access.
    task automatic bus_cycle(input logic [23:0] a, input bit wd, input bit wr,
                             input logic [15:0] d, input int waits);
        bit          a0, use_lo, use_hi;
        logic [7:0]  lo_b, hi_b;
        logic [15:0] exp_rd;
        a0     = a[0];
        use_hi = width_strap && (a0 || wd);
        use_lo = !width_strap || !a0;
        lo_b   = a[7:0] ^ 8'h5A;
        hi_b   = a[7:0] ^ 8'hC3;
        if (use_lo && use_hi) exp_rd = {hi_b, lo_b};
        else if (use_hi)      exp_rd = {8'h00, hi_b};
        else                  exp_rd = {8'h00, lo_b};

        @(negedge clk); req_valid = 1'b0; ready = 1'b0; #1;
        chk(astb == 1'b1, "R2 astb in address phase", astb, 1);
        chk(addr_oe && addr_lo == a[15:0], "R2 low address", addr_lo, a[15:0]);
        chk(mux_oe && mux_out == a[23:16], "R2 upper address on shared lane", mux_out, a[23:16]);
        chk(rd_n && wr_n && strobe_oe, "R2 strobes idle", {rd_n, wr_n}, 2'b11);
        chk(aen && hold_req, "R3 aen in address phase", aen, 1);
        if (width_strap)
            chk(ube_oe && ube_n == !use_hi, "R7 ube encoding", {ube_oe, ube_n}, {1'b1, !use_hi});
        else
            chk(!ube_oe, "R6 ube floats in byte mode", ube_oe, 0);

        for (int i = 0; i <= 1 + waits; i++) begin
            @(negedge clk);
            ready  = (i == 1 + waits);
            dlo_in = lo_b;
            mux_in = hi_b;
            #1;
            chk(wr ? (!wr_n && rd_n) : (!rd_n && wr_n),
                (i >= 2) ? "R4 strobe held by wait" : "R5 strobe low", {rd_n, wr_n},
                wr ? 2'b10 : 2'b01);
            chk(!astb && aen, "R3 aen in strobe", {astb, aen}, 2'b01);
            if (wr) begin
                if (width_strap) begin
                    chk(dlo_oe == use_lo && mux_oe == use_hi, "R7 write lane enables",
                        {dlo_oe, mux_oe}, {use_lo, use_hi});
                    if (use_lo) chk(dlo_out == d[7:0], "R7 low lane write data", dlo_out, d[7:0]);
                    if (use_hi) chk(mux_out == (a0 ? d[7:0] : d[15:8]), "R7 upper lane write data",
                                    mux_out, a0 ? d[7:0] : d[15:8]);
                end else begin
                    chk(dlo_oe && !mux_oe && dlo_out == d[7:0], "R6 byte write lane",
                        {dlo_oe, mux_oe, dlo_out}, {2'b10, d[7:0]});
                end
            end else begin
                chk(!dlo_oe && !mux_oe, "R7 lanes floated on read", {dlo_oe, mux_oe}, 0);
            end
        end

        @(negedge clk); ready = 1'b1; #1;
        chk(done == 1'b1, "R11 done pulse", done, 1);
        chk(rd_n && wr_n && strobe_oe, "R5 strobe ended on time", {rd_n, wr_n}, 2'b11);
        chk(aen && hold_req && addr_oe, "R9 address held in done cycle", {aen, hold_req, addr_oe}, 3'b111);
        if (!wr)
            chk(rdata == exp_rd, width_strap ? "R7 read data" : "R6 read data", rdata, exp_rd);
    endtask

    // Release, then the idle refusal while acknowledge lingers.
    task automatic release_bus();
        req_valid = 1'b0;
        @(negedge clk); #1;
        chk(!done, "R11 done lasts one cycle", done, 0);
        chk(!addr_oe && !strobe_oe && !mux_oe && !dlo_oe && !ube_oe, "R9 lines floated first",
            {addr_oe, strobe_oe, mux_oe, dlo_oe, ube_oe}, 0);
        chk(aen && hold_req, "R9 aen and hold_req kept one cycle", {aen, hold_req}, 2'b11);
        @(negedge clk); #1;
        chk(!hold_req, "R8 hold_req low when idle", hold_req, 0);
        chk_slave("R8 bus floated when idle");
        chk(!req_ready, "R10 refused while ack high", req_ready, 0);
        set_req(24'hFFFFFF, 1'b0, 1'b0, 16'h0);
        @(negedge clk); req_valid = 1'b0; #1;
        chk(!hold_req, "R10 request not taken while ack high", hold_req, 0);
        hold_ack = 1'b0; #1;
        chk(req_ready, "R10 ready after ack low", req_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!hold_req, "R8 reset hold_req", hold_req, 0);
        chk_slave("R8 reset bus floated");
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req_ready, "R10 ready after reset", req_ready, 1);

        for (int s = 0; s < 2; s++) begin
            width_strap = s[0];
            for (int k = 0; k < 32; k++) begin
                logic [23:0] a;
                logic [15:0] d;
                int          idx;
                idx = s * 32 + k;
                a   = (24'h5A1000 ^ (24'(idx) * 24'h010203)) & 24'hFFFFFE;
                a[0] = k[0];
                d   = 16'hB000 + 16'(idx) * 16'h0111;
                @(negedge clk);
                set_req(a, k[1], k[2], d);
                grant(idx % 3);
                bus_cycle(a, k[1], k[2], d, k / 8);
                release_bus();
            end
        end

        // Chained pair: word write at even address, then byte read at odd address.
        width_strap = 1'b1;
        @(negedge clk);
        set_req(24'h123456, 1'b1, 1'b1, 16'hBEEF);
        grant(1);
        bus_cycle(24'h123456, 1'b1, 1'b1, 16'hBEEF, 0);
        set_req(24'h654321, 1'b0, 1'b0, 16'h0);
        #1;
        chk(req_ready, "R12 request taken in done cycle", req_ready, 1);
        bus_cycle(24'h654321, 1'b0, 1'b0, 16'h0, 1);
        chk(hold_req, "R12 bus kept across chain", hold_req, 1);
        release_bus();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule